// File: doc/BRIEF.md
# Fractional-Rate Timestamp Clock

This block keeps a running time of day as a 48-bit seconds count and a nanoseconds count. On every enabled clock cycle the nanoseconds advance by a programmable fixed-point step. The step has an integer mantissa and a binary fraction. The fraction builds up in its own accumulator, and each carry out of it adds one extra nanosecond. When the nanoseconds reach one billion, the block subtracts that amount and adds one to the seconds.

Software uses a small word-wide register port. To set the time, it stages the upper and lower seconds words and then writes the nanoseconds word. That last write moves all three values into the running clock on the same edge. To read the time, it sets a capture flag. The flag freezes the seconds and nanoseconds together into capture registers and clears itself after a fixed number of cycles. A single write of the step register sets the rate and turns counting on or off.

Top module: `tsc_timer`

## Requirements
- R1: After a synchronous active-low reset, every readable word reads zero. The running time is zero, counting is disabled and no capture is pending.
- R2: A write to address 0 (upper seconds, low 16 bits used) or address 1 (lower seconds) only stages the value. Address 0 and address 1 read back the staged values, and the running time stays as it was.
- R3: A write to address 2 loads the staged seconds and the written nanoseconds into the running clock on one edge and clears the fraction accumulator. A written value of 10^9 or more is loaded as zero nanoseconds.
- R4: The step word at address 3 holds the fraction in bits 19:0, the mantissa in bits 29:20 and the enable in bit 31. One write sets the step and the enable together, and address 3 reads back that layout with all other bits zero.
- R5: While counting is enabled, each cycle adds the mantissa plus the carry out of the 20-bit fraction sum to the nanoseconds.
- R6: When the nanoseconds sum reaches 10^9 or more, 10^9 is subtracted and the 48-bit seconds count goes up by one, wrapping from all ones to zero. The nanoseconds stay below 10^9.
- R7: A step word written with bit 31 clear stops the clock, and the time holds its value.
- R8: A write to address 4 with bit 31 set records the running time as it stood just before that edge. It does not change the running time.
- R9: Bit 31 of address 4 reads 1 for exactly 3 cycles after a capture starts and then clears by itself.
- R10: The captured upper seconds read in bits 15:0 of address 4, the captured lower seconds at address 5 and the captured nanoseconds at address 6.
- R11: A write to address 4 with bit 31 clear, or a capture request while one is still pending, leaves the capture registers and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |

## Verification
The assertions check on every cycle that the nanoseconds stay below one billion and that the seconds never move by more than one per cycle. They also check that the time freezes when counting is off, that a load lands the written value, that a capture raises its flag, and that the capture registers change only when a capture is accepted. Other behaviour appears only in the bench scenarios. These include the exact nanosecond total after a run with fractional carries, the 48-bit wrap and the exact flag duration. They also include the snapshot matching the time just before the capture edge and the requests that must be ignored.

// File: rtl/tsc_pkg.sv
// Shared register map and constants for the timestamp clock.
package tsc_pkg;
    localparam int ADDR_W = 3;
    localparam int WORD_W = 32;
    localparam int CTL_BIT = 31;
    localparam logic [WORD_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC_HI = 3'd0,
        A_SEC_LO = 3'd1,
        A_NSEC   = 3'd2,
        A_STEP   = 3'd3,
        A_CAP_HI = 3'd4,
        A_CAP_LO = 3'd5,
        A_CAP_NS = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/tsc_regs.sv
// Write decode: stages seconds words, raises the load strobe on the
// nanoseconds write and holds the step/enable register.
// Assumes FRAC_W + MANT_W <= 31.
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int FRAC_W = 20,
    parameter int MANT_W = 10,
    localparam int HI_W  = SEC_W - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [HI_W-1:0]   stage_hi,
    output logic [WORD_W-1:0] stage_lo,
    output logic              load_req,
    output logic              run_en,
    output logic [MANT_W-1:0] step_mant,
    output logic [FRAC_W-1:0] step_frac,
    output logic [WORD_W-1:0] step_word
);
    // Load strobe is the nanoseconds write itself
    assign load_req = wr_en && (wr_addr == A_NSEC);

    // Staging and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi  <= '0;
            stage_lo  <= '0;
            run_en    <= 1'b0;
            step_mant <= '0;
            step_frac <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_SEC_HI) stage_hi <= wr_data[HI_W-1:0];
            if (wr_addr == A_SEC_LO) stage_lo <= wr_data;
            if (wr_addr == A_STEP) begin
                run_en    <= wr_data[CTL_BIT];
                step_mant <= wr_data[FRAC_W +: MANT_W];
                step_frac <= wr_data[FRAC_W-1:0];
            end
        end
    end

    // Readback image of the step register
    always_comb begin
        step_word = '0;
        step_word[FRAC_W-1:0] = step_frac;
        step_word[FRAC_W +: MANT_W] = step_mant;
        step_word[CTL_BIT] = run_en;
    end
endmodule

// File: rtl/tsc_count.sv
// Running time: fraction accumulator, nanoseconds with rollover at one
// billion, and the seconds count. A load overrides counting.
module tsc_count
    import tsc_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int FRAC_W = 20,
    parameter int MANT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [SEC_W-1:0]  load_sec,
    input  logic [WORD_W-1:0] load_ns,
    input  logic              run_en,
    input  logic [MANT_W-1:0] step_mant,
    input  logic [FRAC_W-1:0] step_frac,
    output logic [SEC_W-1:0]  sec_q,
    output logic [WORD_W-1:0] ns_q
);
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W-1:0] frac_nx;
    logic              carry;
    logic [WORD_W-1:0] ns_sum;
    logic              wrap;

    // Next-step arithmetic
    always_comb begin
        {carry, frac_nx} = {1'b0, frac_q} + {1'b0, step_frac};
        ns_sum = ns_q + WORD_W'(step_mant) + WORD_W'(carry);
        wrap   = (ns_sum >= NS_PER_SEC);
    end

    // Time state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            ns_q   <= '0;
            frac_q <= '0;
        end else if (load_req) begin
            sec_q  <= load_sec;
            ns_q   <= (load_ns >= NS_PER_SEC) ? '0 : load_ns;
            frac_q <= '0;
        end else if (run_en) begin
            frac_q <= frac_nx;
            if (wrap) begin
                ns_q  <= ns_sum - NS_PER_SEC;
                sec_q <= sec_q + SEC_W'(1);
            end else begin
                ns_q  <= ns_sum;
            end
        end
    end
endmodule

// File: rtl/tsc_snap.sv
// Capture unit: freezes seconds and nanoseconds on an accepted request and
// holds a self-clearing pending flag for CAPT_LAT cycles.
module tsc_snap
    import tsc_pkg::*;
#(
    parameter int SEC_W    = 48,
    parameter int CAPT_LAT = 3,
    localparam int CNT_W   = $clog2(CAPT_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [SEC_W-1:0]  sec_in,
    input  logic [WORD_W-1:0] ns_in,
    output logic              pending,
    output logic [SEC_W-1:0]  cap_sec,
    output logic [WORD_W-1:0] cap_ns
);
    logic [CNT_W-1:0] cnt_q;

    assign pending = (cnt_q != '0);

    // Snapshot registers and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cap_sec <= '0;
            cap_ns  <= '0;
        end else if (start_req && !pending) begin
            cnt_q   <= CNT_W'(CAPT_LAT);
            cap_sec <= sec_in;
            cap_ns  <= ns_in;
        end else if (pending) begin
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tsc_timer.sv
// Top of the timestamp clock: ties the register decode, time counter and
// capture unit together and drives the combinational read mux.
module tsc_timer
    import tsc_pkg::*;
#(
    parameter int SEC_W    = 48,
    parameter int FRAC_W   = 20,
    parameter int MANT_W   = 10,
    parameter int CAPT_LAT = 3,
    localparam int HI_W    = SEC_W - WORD_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data
);
    logic [HI_W-1:0]   stage_hi;
    logic [WORD_W-1:0] stage_lo;
    logic              load_req;
    logic              run_en;
    logic [MANT_W-1:0] step_mant;
    logic [FRAC_W-1:0] step_frac;
    logic [WORD_W-1:0] step_word;
    logic [SEC_W-1:0]  sec_now;
    logic [WORD_W-1:0] ns_now;
    logic              cap_start;
    logic              cap_pending;
    logic [SEC_W-1:0]  cap_sec;
    logic [WORD_W-1:0] cap_ns;

    tsc_regs #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stage_hi(stage_hi), .stage_lo(stage_lo),
        .load_req(load_req), .run_en(run_en), .step_mant(step_mant),
        .step_frac(step_frac), .step_word(step_word)
    );

    tsc_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load_req(load_req),
        .load_sec({stage_hi, stage_lo}), .load_ns(wr_data), .run_en(run_en),
        .step_mant(step_mant), .step_frac(step_frac),
        .sec_q(sec_now), .ns_q(ns_now)
    );

    assign cap_start = wr_en && (wr_addr == A_CAP_HI) && wr_data[CTL_BIT];

    tsc_snap #(.SEC_W(SEC_W), .CAPT_LAT(CAPT_LAT)) u_snap (
        .clk(clk), .rst_n(rst_n), .start_req(cap_start), .sec_in(sec_now),
        .ns_in(ns_now), .pending(cap_pending), .cap_sec(cap_sec), .cap_ns(cap_ns)
    );

    // Read mux over staged, step and captured words
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SEC_HI: rd_data[HI_W-1:0] = stage_hi;
            A_SEC_LO: rd_data = stage_lo;
            A_STEP:   rd_data = step_word;
            A_CAP_HI: begin
                rd_data[HI_W-1:0] = cap_sec[SEC_W-1:WORD_W];
                rd_data[CTL_BIT]  = cap_pending;
            end
            A_CAP_LO: rd_data = cap_sec[WORD_W-1:0];
            A_CAP_NS: rd_data = cap_ns;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tsc_timer_chk.sv
// Property checker for tsc_timer, attached by bind. Observes the write
// port, the running time and the capture registers.
module tsc_timer_chk #(
    parameter int SEC_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic              run_en,
    input logic              load_req,
    input logic [SEC_W-1:0]  sec_now,
    input logic [31:0]       ns_now,
    input logic              cap_pending,
    input logic [SEC_W-1:0]  cap_sec,
    input logic [31:0]       cap_ns
);
    localparam logic [31:0] BILLION = 32'd1_000_000_000;
    logic take;
    assign take = wr_en && (wr_addr == 3'd4) && wr_data[31] && !cap_pending;

    // R6
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ns_now < BILLION);

    // R6
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_req) |=>
        (sec_now == $past(sec_now) || sec_now == $past(sec_now) + SEC_W'(1)));

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_req) |=> ($stable(ns_now) && $stable(sec_now)));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && wr_data < BILLION) |=> (ns_now == $past(wr_data)));

    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cap_pending);

    // R11
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(cap_ns) && $stable(cap_sec)));
endmodule

bind tsc_timer tsc_timer_chk #(.SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run_en(run_en), .load_req(load_req),
    .sec_now(sec_now), .ns_now(ns_now), .cap_pending(cap_pending),
    .cap_sec(cap_sec), .cap_ns(cap_ns)
);

// File: tb/tsc_timer_test.sv
// Bench for tsc_timer: a reference model stepped on each rising edge,
// directed corners plus seeded random operations, all reads compared.
module tsc_timer_test;
    localparam int CAPT_LAT = 3;
    localparam logic [31:0] BILLION = 32'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tsc_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Reference model state
    logic [47:0] m_sec, m_csec;
    logic [31:0] m_ns, m_cns, m_slo;
    logic [15:0] m_shi;
    logic [19:0] m_facc, m_frac;
    logic [9:0]  m_mant;
    logic        m_en;
    int          m_cnt;

    always @(posedge clk) begin
        logic [20:0] fs;
        logic [31:0] nsum;
        if (!rst_n) begin
            m_sec = '0; m_ns = '0; m_facc = '0; m_en = 0; m_mant = '0;
            m_frac = '0; m_shi = '0; m_slo = '0; m_cnt = 0;
            m_csec = '0; m_cns = '0;
        end else begin
            // capture uses pre-edge time
            if (wr_en && wr_addr == 3'd4 && wr_data[31] && m_cnt == 0) begin
                m_csec = m_sec; m_cns = m_ns; m_cnt = CAPT_LAT;
            end else if (m_cnt != 0) m_cnt = m_cnt - 1;
            // time update with pre-edge step settings
            if (wr_en && wr_addr == 3'd2) begin
                m_sec = {m_shi, m_slo};
                m_ns = (wr_data >= BILLION) ? 32'd0 : wr_data;
                m_facc = '0;
            end else if (m_en) begin
                fs = {1'b0, m_facc} + {1'b0, m_frac};
                m_facc = fs[19:0];
                nsum = m_ns + {22'd0, m_mant} + {31'd0, fs[20]};
                if (nsum >= BILLION) begin
                    m_ns = nsum - BILLION; m_sec = m_sec + 48'd1;
                end else m_ns = nsum;
            end
            if (wr_en && wr_addr == 3'd0) m_shi = wr_data[15:0];
            if (wr_en && wr_addr == 3'd1) m_slo = wr_data;
            if (wr_en && wr_addr == 3'd3) begin
                m_en = wr_data[31]; m_mant = wr_data[29:20]; m_frac = wr_data[19:0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'd0, m_shi};
            3'd1: return m_slo;
            3'd3: return {m_en, 1'b0, m_mant, m_frac};
            3'd4: return {(m_cnt != 0), 15'd0, m_csec[47:32]};
            3'd5: return m_csec[31:0];
            3'd6: return m_cns;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a);
        @(negedge clk);
        rd_addr = a;
        #1 check(tag, rd_data, exp_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Start a capture, count flag cycles, then read the three captured words
    task automatic capture(input string tag);
        int hi_cnt = 0;
        wr(3'd4, 32'h8000_0000);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            rd_addr = 3'd4;
            #1 check("R9", rd_data, exp_read(3'd4));
            if (rd_data[31]) hi_cnt++;
            else break;
        end
        check("R9", 32'(hi_cnt), 32'(CAPT_LAT));
        rd_chk(tag, 3'd4);
        rd_chk(tag, 3'd5);
        rd_chk(tag, 3'd6);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a));

        // R2 staging only
        wr(3'd0, 32'hABCD_1234);
        wr(3'd1, 32'h0000_0777);
        rd_chk("R2", 3'd0);
        rd_chk("R2", 3'd1);
        capture("R2");

        // R3 load and R10 captured word positions
        wr(3'd2, 32'd500);
        capture("R10");
        wr(3'd2, BILLION + 32'd5);
        capture("R3");

        // R4/R5 step with half-nanosecond fraction
        wr(3'd3, {1'b1, 1'b0, 10'd8, 20'h80000});
        rd_chk("R4", 3'd3);
        idle(11);
        capture("R5");

        // R6 rollover and 48-bit wrap
        wr(3'd0, 32'h0000_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, {1'b1, 1'b0, 10'd7, 20'h00000});
        wr(3'd2, 32'd999_999_990);
        idle(3);
        capture("R6");

        // R7 disable freezes time
        wr(3'd3, 32'h0000_0000);
        capture("R7");
        idle(20);
        capture("R7");

        // R8 running time untouched by capture
        wr(3'd3, {1'b1, 1'b0, 10'd3, 20'h40000});
        capture("R8");
        capture("R8");

        // R11 ignored requests: bit clear, then repeat while pending
        wr(3'd4, 32'h0000_0000);
        rd_chk("R11", 3'd4);
        rd_chk("R11", 3'd6);
        wr(3'd4, 32'h8000_0000);
        wr(3'd4, 32'h8000_0000);
        rd_chk("R11", 3'd5);
        rd_chk("R11", 3'd6);
        idle(5);

        // Seeded random operations
        for (int i = 0; i < 40; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: begin
                    wr(3'd0, $urandom());
                    wr(3'd1, $urandom());
                    wr(3'd2, $urandom_range(0, 1_100_000_000));
                end
                1: wr(3'd3, {($urandom_range(0, 3) != 0), 1'b0, 10'($urandom()), 20'($urandom())});
                2: idle(int'($urandom_range(1, 40)));
                default: ;
            endcase
            capture("R5");
            rd_chk("R4", 3'd3);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule